// File: doc/BRIEF.md
# Output Switch Fault Supervisor

This block sits between a bank of power output switches and their analog sense circuits. It takes comparator flags that have already been digitized: supply undervoltage, open-load and overcurrent for each channel, two thermal-warning flags, two thermal-shutdown flags and an active-low inhibit pin. It qualifies each fault with its own cycle-count delay, keeps sticky fault flags, tracks a live thermal-warning flag and gates the enable of every channel.

Channel on/off requests and two control bits arrive in a 16-bit serial command word. One control bit clears the sticky flags (clear request). The other selects whether an overcurrent turns its channel off (overcurrent cutoff). The block also presents the thermal-warning flag on the serial data output as soon as chip select falls. A host can therefore poll it without shifting a whole word.

Each fault kind recovers in its own way. Undervoltage releases the outputs at once but leaves its flag set. A thermal shutdown holds until the die has cooled and a clear request arrives. An overcurrent cutoff holds until a clear request arrives. Open load only raises a flag.

Top module: `fsup_top`

## Requirements
- R1: While `cs_n` is low, each rising `sclk` shifts `sdi` into the command word, most significant bit first. On the rising edge of `cs_n`, a word of at least WORD_W bits is accepted. Bits [N_CH-1:0] are the channel requests, bit WORD_W-2 is overcurrent cutoff and bit WORD_W-1 is clear request. `ch_en` then follows the requests.
- R2: If `cs_n` rises after fewer than WORD_W bits, the transfer is dropped. Channel requests, the cutoff setting and all flags keep their values.
- R3: An undervoltage shorter than UV_DLY cycles has no effect. Once `uv_raw` has been high for UV_DLY consecutive cycles, every `ch_en` bit is low and `psf` is set on the next cycle.
- R4: When `uv_raw` drops, `ch_en` returns to the requested pattern in the same cycle. `psf` stays set until a clear request.
- R5: Open load on a channel that is enabled for SD_DLY consecutive cycles sets `opl`. Open load on a disabled channel is ignored. `opl` stays set until a clear request.
- R6: With overcurrent cutoff at 0, an overcurrent lasting SD_DLY cycles sets `scd` and leaves `ch_en` unchanged.
- R7: With overcurrent cutoff at 1, the same overcurrent also turns that channel's `ch_en` off. The channel stays off after the current drops. A clear request re-enables it and clears `scd`.
- R8: `tsd_raw` high turns every `ch_en` bit off from the next cycle. A clear request while `ton_raw` is low leaves them off. A clear request while `ton_raw` is high restores them.
- R9: `tp` is set by `tp_hi`, held while both flags are low, and cleared by `tp_lo`. When both flags are high, set wins.
- R10: One cycle after `cs_n` is sampled falling, `sdo` carries the value `tp` had at that edge. `sdo` is low while `cs_n` is high.
- R11: A clear request that arrives while a fault is still qualified leaves that fault's flag set.
- R12: `inh_n` low drives `ch_hiz` high and every `ch_en` bit low at once. It clears all flags, requests and settings. After `inh_n` returns high, the block is in its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inh_n | input | 1 | Inhibit, active low |
| uv_raw | input | 1 | Supply undervoltage comparator |
| ol_raw | input | N_CH | Open-load comparator for each channel |
| oc_raw | input | N_CH | Overcurrent comparator for each channel |
| tp_hi | input | 1 | Die temperature above the warning set threshold |
| tp_lo | input | 1 | Die temperature below the warning release threshold |
| tsd_raw | input | 1 | Die temperature above the shutdown threshold |
| ton_raw | input | 1 | Die temperature below the restart threshold |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (first bit: thermal warning) |
| ch_en | output | N_CH | Channel enable and channel status |
| ch_hiz | output | 1 | All switches high impedance |
| psf | output | 1 | Sticky supply-fail flag |
| opl | output | 1 | Sticky open-load flag |
| scd | output | 1 | Sticky overcurrent flag |
| tp | output | 1 | Live thermal-warning flag |

## Verification
The bench builds the block with four channels, a 16-bit word, UV_DLY = 5 and SD_DLY = 3. With delays this short, a fault held for one cycle less than its delay can be checked against one held for exactly its delay within a few dozen cycles. The same holds for faults that persist through a clear request. Four channels are enough to mix enabled and disabled channels in one request pattern. This shows that open load on an off channel is ignored, and that an overcurrent cutoff removes only the channel that tripped.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

   // Control bit positions, counted down from the top of the command word
   localparam int unsigned CLR_FROM_TOP = 0;
   localparam int unsigned CUT_FROM_TOP = 1;

   // Width of a counter that must hold the value lim
   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/fsup_debounce.sv
module fsup_debounce #(
   parameter int unsigned DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic raw,
   output logic qual
);
   localparam int unsigned CW = fsup_pkg::cnt_width(DLY);
   localparam logic [CW-1:0] TERM = CW'(DLY);

   logic [CW-1:0] cnt;

   // Any low cycle restarts the count; the count saturates at TERM
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr || !raw) begin
         cnt <= '0;
      end else if (cnt != TERM) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign qual = (cnt == TERM);

endmodule

// File: rtl/fsup_serial_rx.sv
module fsup_serial_rx #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned N_CH   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            cs_n,
   input  logic            sclk,
   input  logic            sdi,
   input  logic            tp,
   output logic            sdo,
   output logic            word_vld,
   output logic [N_CH-1:0] w_req,
   output logic            w_cut,
   output logic            w_clr
);
   localparam int unsigned BW = fsup_pkg::cnt_width(WORD_W);
   localparam logic [BW-1:0] FULL = BW'(WORD_W);

   logic              cs_q;
   logic              sclk_q;
   logic [WORD_W-1:0] shreg;
   logic [BW-1:0]     bcnt;
   logic              cs_fall;
   logic              cs_rise;
   logic              sclk_rise;

   assign cs_fall   =  cs_q & ~cs_n;
   assign cs_rise   = ~cs_q &  cs_n;
   assign sclk_rise =  sclk & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
         shreg  <= '0;
         bcnt   <= '0;
         sdo    <= 1'b0;
      end else if (clr) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
         shreg  <= '0;
         bcnt   <= '0;
         sdo    <= 1'b0;
      end else begin
         cs_q   <= cs_n;
         sclk_q <= sclk;
         if (cs_fall) begin
            bcnt <= '0;
         end else if (!cs_n && sclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], sdi};
            if (bcnt != FULL) bcnt <= bcnt + 1'b1;
         end
         // First output bit is the live warning flag captured at select
         if (cs_fall) begin
            sdo <= tp;
         end else if (cs_n) begin
            sdo <= 1'b0;
         end
      end
   end

   assign word_vld = cs_rise && (bcnt == FULL);
   assign w_req    = shreg[N_CH-1:0];
   assign w_cut    = shreg[WORD_W-1-fsup_pkg::CUT_FROM_TOP];
   assign w_clr    = shreg[WORD_W-1-fsup_pkg::CLR_FROM_TOP];

endmodule

// File: rtl/fsup_channel.sv
module fsup_channel #(
   parameter int unsigned SD_DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic on,
   input  logic ol_raw,
   input  logic oc_raw,
   input  logic cut_en,
   input  logic clr_req,
   output logic ol_q,
   output logic oc_q,
   output logic oc_off
);
   logic ol_live;
   logic oc_live;

   // Sense conditions only count while the switch is driven
   assign ol_live = ol_raw & on;
   assign oc_live = oc_raw & on;

   fsup_debounce #(.DLY(SD_DLY)) u_ol_dly (
      .clk(clk), .rst_n(rst_n), .clr(clr), .raw(ol_live), .qual(ol_q)
   );

   fsup_debounce #(.DLY(SD_DLY)) u_oc_dly (
      .clk(clk), .rst_n(rst_n), .clr(clr), .raw(oc_live), .qual(oc_q)
   );

   // Cutoff latch: a qualified trip outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_off <= 1'b0;
      end else if (clr) begin
         oc_off <= 1'b0;
      end else if (oc_q && cut_en) begin
         oc_off <= 1'b1;
      end else if (clr_req) begin
         oc_off <= 1'b0;
      end
   end

endmodule

// File: rtl/fsup_top.sv
module fsup_top #(
   parameter int unsigned N_CH   = 6,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned UV_DLY = 1000,
   parameter int unsigned SD_DLY = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inh_n,
   input  logic            uv_raw,
   input  logic [N_CH-1:0] ol_raw,
   input  logic [N_CH-1:0] oc_raw,
   input  logic            tp_hi,
   input  logic            tp_lo,
   input  logic            tsd_raw,
   input  logic            ton_raw,
   input  logic            cs_n,
   input  logic            sclk,
   input  logic            sdi,
   output logic            sdo,
   output logic [N_CH-1:0] ch_en,
   output logic            ch_hiz,
   output logic            psf,
   output logic            opl,
   output logic            scd,
   output logic            tp
);
   // Elaboration-time parameter checks
   if (N_CH < 1) begin : g_bad_nch
      $error("fsup_top: N_CH must be at least 1");
   end
   if (WORD_W < N_CH + 2) begin : g_bad_word
      $error("fsup_top: WORD_W must hold N_CH request bits plus two control bits");
   end
   if (UV_DLY < 1 || SD_DLY < 1) begin : g_bad_dly
      $error("fsup_top: qualification delays must be at least one cycle");
   end

   logic            clr;
   logic            word_vld;
   logic [N_CH-1:0] w_req;
   logic            w_cut;
   logic            w_clr;
   logic            srr_pulse;
   logic [N_CH-1:0] cmd;
   logic            cut_en;
   logic            tsd_lock;
   logic            uv_q;
   logic            uv_act;
   logic [N_CH-1:0] ol_q;
   logic [N_CH-1:0] oc_q;
   logic [N_CH-1:0] oc_off;

   assign clr = ~inh_n;

   fsup_serial_rx #(.WORD_W(WORD_W), .N_CH(N_CH)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .tp(tp), .sdo(sdo),
      .word_vld(word_vld), .w_req(w_req), .w_cut(w_cut), .w_clr(w_clr)
   );

   assign srr_pulse = word_vld & w_clr;

   fsup_debounce #(.DLY(UV_DLY)) u_uv_dly (
      .clk(clk), .rst_n(rst_n), .clr(clr), .raw(uv_raw), .qual(uv_q)
   );

   // Undervoltage holds the outputs only while the supply is actually low
   assign uv_act = uv_q & uv_raw;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      fsup_channel #(.SD_DLY(SD_DLY)) u_ch (
         .clk(clk), .rst_n(rst_n), .clr(clr),
         .on(ch_en[i]), .ol_raw(ol_raw[i]), .oc_raw(oc_raw[i]),
         .cut_en(cut_en), .clr_req(srr_pulse),
         .ol_q(ol_q[i]), .oc_q(oc_q[i]), .oc_off(oc_off[i])
      );
   end

   assign ch_en  = {N_CH{inh_n & ~tsd_lock & ~uv_act}} & cmd & ~oc_off;
   assign ch_hiz = ~inh_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd      <= '0;
         cut_en   <= 1'b0;
         tsd_lock <= 1'b0;
         psf      <= 1'b0;
         opl      <= 1'b0;
         scd      <= 1'b0;
         tp       <= 1'b0;
      end else if (clr) begin
         cmd      <= '0;
         cut_en   <= 1'b0;
         tsd_lock <= 1'b0;
         psf      <= 1'b0;
         opl      <= 1'b0;
         scd      <= 1'b0;
         tp       <= 1'b0;
      end else begin
         if (word_vld) begin
            cmd    <= w_req;
            cut_en <= w_cut;
         end
         if (tsd_raw) begin
            tsd_lock <= 1'b1;
         end else if (srr_pulse && ton_raw) begin
            tsd_lock <= 1'b0;
         end
         // A fault still qualified outranks a clear request
         if (uv_q) begin
            psf <= 1'b1;
         end else if (srr_pulse) begin
            psf <= 1'b0;
         end
         if (|ol_q) begin
            opl <= 1'b1;
         end else if (srr_pulse) begin
            opl <= 1'b0;
         end
         if (|oc_q) begin
            scd <= 1'b1;
         end else if (srr_pulse) begin
            scd <= 1'b0;
         end
         if (tp_hi) begin
            tp <= 1'b1;
         end else if (tp_lo) begin
            tp <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
   parameter int unsigned N_CH = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            inh_n,
   input logic            cs_n,
   input logic            tp,
   input logic            sdo,
   input logic            psf,
   input logic            opl,
   input logic            scd,
   input logic [N_CH-1:0] ch_en,
   input logic            tsd_raw,
   input logic            tp_hi,
   input logic            srr_pulse,
   input logic            word_vld,
   input logic [N_CH-1:0] cmd
);

   // R12
   inh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inh_n |=> (!psf && !opl && !scd && !tp && ch_en == '0));

   // R4
   psf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !inh_n)
      (psf && !srr_pulse) |=> psf);

   // R5
   opl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !inh_n)
      (opl && !srr_pulse) |=> opl);

   // R7
   scd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !inh_n)
      (scd && !srr_pulse) |=> scd);

   // R8
   tsd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_raw |=> (ch_en == '0));

   // R9
   tp_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !inh_n)
      tp_hi |=> tp);

   // R10
   sdo_first_chk: assert property (@(posedge clk) disable iff (!rst_n || !inh_n)
      $fell(cs_n) |=> (sdo == $past(tp)));

   // R2
   abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || !inh_n)
      ($rose(cs_n) && !word_vld) |=> $stable(cmd));

endmodule

bind fsup_top fsup_checker #(.N_CH(N_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .inh_n(inh_n), .cs_n(cs_n), .tp(tp), .sdo(sdo),
   .psf(psf), .opl(opl), .scd(scd), .ch_en(ch_en), .tsd_raw(tsd_raw),
   .tp_hi(tp_hi), .srr_pulse(srr_pulse), .word_vld(word_vld), .cmd(cmd)
);

// File: tb/tb_fsup_top.sv
module tb_fsup_top;
   localparam int unsigned N  = 4;
   localparam int unsigned W  = 16;
   localparam int unsigned UD = 5;
   localparam int unsigned SD = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         inh_n = 1'b1;
   logic         uv_raw = 1'b0;
   logic [N-1:0] ol_raw = '0;
   logic [N-1:0] oc_raw = '0;
   logic         tp_hi = 1'b0;
   logic         tp_lo = 1'b0;
   logic         tsd_raw = 1'b0;
   logic         ton_raw = 1'b0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         sdi = 1'b0;
   logic         sdo;
   logic [N-1:0] ch_en;
   logic         ch_hiz;
   logic         psf;
   logic         opl;
   logic         scd;
   logic         tp;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   fsup_top #(.N_CH(N), .WORD_W(W), .UV_DLY(UD), .SD_DLY(SD)) dut (
      .clk(clk), .rst_n(rst_n), .inh_n(inh_n), .uv_raw(uv_raw),
      .ol_raw(ol_raw), .oc_raw(oc_raw), .tp_hi(tp_hi), .tp_lo(tp_lo),
      .tsd_raw(tsd_raw), .ton_raw(ton_raw), .cs_n(cs_n), .sclk(sclk),
      .sdi(sdi), .sdo(sdo), .ch_en(ch_en), .ch_hiz(ch_hiz), .psf(psf),
      .opl(opl), .scd(scd), .tp(tp)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Word layout: [15] clear request, [14] overcurrent cutoff, [3:0] channel requests
   function automatic logic [W-1:0] mk(input logic [N-1:0] req, input logic cut, input logic clrq);
      logic [W-1:0] w = '0;
      w[N-1:0] = req;
      w[W-2]   = cut;
      w[W-1]   = clrq;
      return w;
   endfunction

   task automatic send_word(input logic [W-1:0] w, input int nbits);
      cs_n = 1'b0;
      tick(2);
      for (int i = 0; i < nbits; i++) begin
         sdi = w[W-1-i];
         tick(1);
         sclk = 1'b1;
         tick(2);
         sclk = 1'b0;
         tick(1);
      end
      cs_n = 1'b1;
      tick(3);
   endtask

   task automatic t_reset;
      check("R12 reset ch_en", 32'(ch_en), 0);
      check("R12 reset flags", {psf, opl, scd, tp, sdo, ch_hiz}, 0);
   endtask

   task automatic t_word;
      send_word(mk(4'b0110, 1'b0, 1'b0), W);
      check("R1 pattern 0110", 32'(ch_en), 32'b0110);
      send_word(mk(4'b1011, 1'b0, 1'b0), W);
      check("R1 pattern 1011", 32'(ch_en), 32'b1011);
   endtask

   task automatic t_abort;
      send_word(mk(4'b0000, 1'b1, 1'b1), 10);
      check("R2 short word ignored", 32'(ch_en), 32'b1011);
      send_word(mk(4'b0000, 1'b0, 1'b0), 0);
      check("R2 empty select ignored", 32'(ch_en), 32'b1011);
   endtask

   task automatic t_uv;
      uv_raw = 1'b1; tick(UD - 1); uv_raw = 1'b0; tick(2);
      check("R3 short undervoltage psf", 32'(psf), 0);
      check("R3 short undervoltage ch_en", 32'(ch_en), 32'b1011);
      uv_raw = 1'b1; tick(UD);
      check("R3 outputs off at delay", 32'(ch_en), 0);
      tick(1);
      check("R3 psf set", 32'(psf), 1);
      send_word(mk(4'b1011, 1'b0, 1'b1), W);
      check("R11 clear during undervoltage", 32'(psf), 1);
      uv_raw = 1'b0; #0.5;
      check("R4 outputs back at once", 32'(ch_en), 32'b1011);
      tick(2);
      check("R4 psf sticky", 32'(psf), 1);
      send_word(mk(4'b1011, 1'b0, 1'b1), W);
      check("R4 psf cleared", 32'(psf), 0);
   endtask

   task automatic t_ol;
      ol_raw = 4'b0100; tick(SD + 3);
      check("R5 open load on off channel", 32'(opl), 0);
      ol_raw = 4'b0001; tick(SD + 2);
      check("R5 open load on channel 0", 32'(opl), 1);
      ol_raw = '0; tick(2);
      check("R5 opl sticky", 32'(opl), 1);
      send_word(mk(4'b1011, 1'b0, 1'b1), W);
      check("R5 opl cleared", 32'(opl), 0);
   endtask

   task automatic t_oc_flag;
      oc_raw = 4'b0010; tick(SD + 2);
      check("R6 scd set without cutoff", 32'(scd), 1);
      check("R6 outputs untouched", 32'(ch_en), 32'b1011);
      oc_raw = '0;
      send_word(mk(4'b1011, 1'b1, 1'b1), W);
      check("R6 scd cleared", 32'(scd), 0);
   endtask

   task automatic t_oc_cut;
      oc_raw = 4'b0010; tick(SD + 2);
      check("R7 channel 1 cut", 32'(ch_en), 32'b1001);
      check("R7 scd set", 32'(scd), 1);
      oc_raw = '0; tick(3);
      check("R7 cut held", 32'(ch_en), 32'b1001);
      send_word(mk(4'b1011, 1'b1, 1'b1), W);
      check("R7 channel restored", 32'(ch_en), 32'b1011);
      check("R7 scd cleared", 32'(scd), 0);
   endtask

   task automatic t_tsd;
      tsd_raw = 1'b1; tick(1); tsd_raw = 1'b0;
      check("R8 shutdown", 32'(ch_en), 0);
      ton_raw = 1'b0;
      send_word(mk(4'b1011, 1'b1, 1'b1), W);
      check("R8 clear while hot", 32'(ch_en), 0);
      ton_raw = 1'b1;
      send_word(mk(4'b1011, 1'b1, 1'b1), W);
      check("R8 clear when cool", 32'(ch_en), 32'b1011);
   endtask

   task automatic t_tp;
      tp_hi = 1'b1; tick(1); tp_hi = 1'b0; tick(2);
      check("R9 tp held", 32'(tp), 1);
      cs_n = 1'b0; tick(1);
      check("R10 sdo shows tp", 32'(sdo), 1);
      cs_n = 1'b1; tick(2);
      check("R10 sdo idle low", 32'(sdo), 0);
      tp_lo = 1'b1; tick(1); tp_lo = 1'b0;
      check("R9 tp cleared", 32'(tp), 0);
      cs_n = 1'b0; tick(1);
      check("R10 sdo shows cool", 32'(sdo), 0);
      cs_n = 1'b1; tick(2);
      tp_hi = 1'b1; tp_lo = 1'b1; tick(1); tp_hi = 1'b0; tp_lo = 1'b0;
      check("R9 set wins", 32'(tp), 1);
   endtask

   task automatic t_inh;
      ol_raw = 4'b0001; tick(SD + 2); ol_raw = '0;
      inh_n = 1'b0; #0.5;
      check("R12 hiz on inhibit", {31'd0, ch_hiz}, 1);
      check("R12 outputs off on inhibit", 32'(ch_en), 0);
      tick(2);
      check("R12 flags cleared", {psf, opl, scd, tp}, 0);
      inh_n = 1'b1; tick(2);
      check("R12 requests cleared", 32'(ch_en), 0);
      check("R12 hiz released", 32'(ch_hiz), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_word();
      t_abort();
      t_uv();
      t_ol();
      t_oc_flag();
      t_oc_cut();
      t_tsd();
      t_tp();
      t_inh();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule